// File: doc/BRIEF.md
# SPI Two-Node Bus Takeover Controller

This block is one SPI node in a two-node system. At rest it behaves as a slave: it drives MISO only while its select is active, and it shifts out a prepared byte on the peer's clock. On a start request it becomes master. It then drives the peer's select low through a dedicated output, generates SCK from a programmable even divider and sends one 8-bit frame in SPI mode 0 (MSB first). After the frame it issues a done pulse, releases the peer's select and drops back to slave.

The local select can come from three sources. In software mode the select is a control bit and the NSS pin is ignored. In hardware input mode the synchronized NSS pin is used. In hardware output mode NSS is driven low during the node's own master session. In either input mode, a select seen low while the node is master is a bus collision. The node then releases all bus outputs at once, sets a sticky fault flag and starts a programmable back-off count. When the count expires it retries the same byte, unless it was selected as a slave during the back-off. Each of the two peers is given a different back-off so that a second clash is avoided.

Top module: `spi_mm_node`

## Requirements
- R1: After reset, and whenever idle, the node is a slave: master_o=0, sck_oe_o=0, mosi_oe_o=0, nss_oe_o=0, peer_sel_o=1, fault_o=0, done_o=0.
- R2: A start_i pulse accepted in idle makes master_o=1, peer_sel_o=0 and sck_oe_o=mosi_oe_o=1 for exactly 8*clk_div_i clock cycles (clk_div_i even, at least 2).
- R3: As master, SCK idles low and each bit lasts clk_div_i cycles. mosi_o carries tx_data_i MSB first and changes only on SCK falling edges. miso_i is sampled on SCK rising edges, and rx_data_o holds the received byte once the frame ends.
- R4: done_o is a single-cycle pulse in the first cycle after master_o falls at the end of a complete frame. peer_sel_o is high in that same cycle.
- R5: As a slave, miso_oe_o=1 exactly while the node is not master and the local select is low. miso_o presents slv_tx_data_i MSB first and advances after each falling edge of sck_i. mosi_i is sampled on rising edges of sck_i. After 8 rising edges slv_rx_data_o holds the byte and slv_rx_valid_o pulses.
- R6: With sw_sel_en_i=1 the local select equals sw_sel_val_i (0 = selected) and nss_i has no effect.
- R7: In an input mode (sw_sel_en_i=1, or sel_out_en_i=0), a low local select while master is a fault. master_o falls on the next clock, and SCK, MOSI and the peer select are released.
- R8: With sw_sel_en_i=0 and sel_out_en_i=1, nss_oe_o=1 and nss_o=0 during the master session, and a low nss_i does not cause a fault.
- R9: fault_o is set by a fault and stays set until a cycle with fault_clr_i=1. A fault in the same cycle takes priority over the clear.
- R10: After a fault, master_o stays low for exactly backoff_i+1 cycles. The node then retransmits the byte latched at the original start.
- R11: If the node is selected as a slave during the back-off, the retry is cancelled and the node stays idle.
- R12: start_i is ignored while the node is selected as a slave.
- R13: nss_i passes through two flops: a change before clock edge k takes effect after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_sel_en_i | input | 1 | Select taken from sw_sel_val_i instead of nss_i |
| sw_sel_val_i | input | 1 | Software select level, 0 = selected |
| sel_out_en_i | input | 1 | In hardware mode, NSS is an output while master |
| start_i | input | 1 | Request a master frame |
| tx_data_i | input | FRAME_W | Byte to send as master |
| clk_div_i | input | DIV_W | SCK period in system clocks (even) |
| backoff_i | input | BO_W | Back-off cycle count after a fault |
| fault_clr_i | input | 1 | Clears the fault flag when 1 |
| slv_tx_data_i | input | FRAME_W | Byte presented on MISO as slave |
| master_o | output | 1 | Node is master |
| done_o | output | 1 | Master frame completed pulse |
| rx_data_o | output | FRAME_W | Byte received as master |
| fault_o | output | 1 | Sticky mode fault flag |
| slv_rx_data_o | output | FRAME_W | Byte received as slave |
| slv_rx_valid_o | output | 1 | Slave byte received pulse |
| sck_o | output | 1 | SCK out |
| sck_oe_o | output | 1 | SCK output enable |
| mosi_o | output | 1 | MOSI out |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO in (master) |
| sck_i | input | 1 | SCK in (slave) |
| mosi_i | input | 1 | MOSI in (slave) |
| miso_o | output | 1 | MISO out (slave) |
| miso_oe_o | output | 1 | MISO output enable |
| nss_i | input | 1 | NSS pin in |
| nss_o | output | 1 | NSS pin out |
| nss_oe_o | output | 1 | NSS output enable |
| peer_sel_o | output | 1 | Peer select, active low |

## Verification
The master path is driven from a vector table. Bytes with alternating, all-zero, all-one and edge-only bit patterns separate a bit-order error from a stuck or shifted line. Divider values of 2, 4, 6 and 8 separate a correct frame length from an off-by-one half period. Straight and inverted loopback of MOSI onto MISO show whether the receive side samples the peer line or only echoes the transmit register. The select sources are then exercised one at a time. A one-cycle NSS glitch during a master session must cause a fault in input mode and must not in output mode. A long software select must cancel the retry, while a short pulse must let the retry come out after exactly the programmed back-off.

// File: rtl/spi_mm_pkg.sv
`timescale 1ns/1ps
package spi_mm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_XFER    = 2'd1,
    ST_BACKOFF = 2'd2
  } node_st_e;
endpackage

// File: rtl/spi_mm_sync.sv
`timescale 1ns/1ps
module spi_mm_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spi_mm_master_shift.sv
`timescale 1ns/1ps
module spi_mm_master_shift #(
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned DIV_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               run_i,
  input  logic [DIV_W-1:0]   half_m1_i,
  input  logic [FRAME_W-1:0] data_i,
  input  logic               miso_i,
  output logic               sck_o,
  output logic               mosi_o,
  output logic               fin_o,
  output logic [FRAME_W-1:0] rx_o
);
  localparam int unsigned CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;

  logic [DIV_W-1:0]   div_q;
  logic               sck_q;
  logic [FRAME_W-1:0] sh_q, rx_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               tick;

  assign tick = (div_q == half_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sck_q <= 1'b0;
      sh_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      div_q <= '0;
      sck_q <= 1'b0;
      sh_q  <= data_i;
      cnt_q <= '0;
    end else if (run_i) begin
      if (tick) begin
        div_q <= '0;
        sck_q <= ~sck_q;
        if (!sck_q) begin
          rx_q <= {rx_q[FRAME_W-2:0], miso_i};
        end else begin
          sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end

  assign fin_o  = run_i & tick & sck_q & (cnt_q == CNT_W'(FRAME_W - 1));
  assign sck_o  = sck_q;
  assign mosi_o = sh_q[FRAME_W-1];
  assign rx_o   = rx_q;

  // MOSI may only move on a falling SCK edge
  p_mosi_stable_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && tick && !sck_q) |=> $stable(mosi_o));
endmodule

// File: rtl/spi_mm_slave_shift.sv
`timescale 1ns/1ps
module spi_mm_slave_shift #(
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               sck_s_i,
  input  logic               mosi_s_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  output logic               miso_o,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               rx_valid_o
);
  localparam int unsigned CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;

  logic               sck_prev_q;
  logic [FRAME_W-1:0] txs_q, rxs_q, rx_data_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               valid_q;
  logic               rise, fall;

  assign rise = sck_s_i & ~sck_prev_q;
  assign fall = ~sck_s_i & sck_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev_q <= 1'b0;
      txs_q      <= '0;
      rxs_q      <= '0;
      rx_data_q  <= '0;
      cnt_q      <= '0;
      valid_q    <= 1'b0;
    end else begin
      sck_prev_q <= sck_s_i;
      valid_q    <= 1'b0;
      if (!sel_i) begin
        txs_q <= tx_data_i;
        cnt_q <= '0;
      end else begin
        if (rise) begin
          rxs_q <= {rxs_q[FRAME_W-2:0], mosi_s_i};
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(FRAME_W - 1)) begin
            rx_data_q <= {rxs_q[FRAME_W-2:0], mosi_s_i};
            valid_q   <= 1'b1;
          end
        end
        if (fall) txs_q <= {txs_q[FRAME_W-2:0], 1'b0};
      end
    end
  end

  assign miso_o     = txs_q[FRAME_W-1];
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = valid_q;

  p_valid_needs_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(sel_i));
endmodule

// File: rtl/spi_mm_backoff.sv
`timescale 1ns/1ps
module spi_mm_backoff #(
  parameter int unsigned BO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            run_i,
  input  logic [BO_W-1:0] val_i,
  output logic            zero_o
);
  logic [BO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= val_i;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - BO_W'(1);
  end

  assign zero_o = (cnt_q == '0);

  p_cnt_dec_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && run_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - BO_W'(1)));
endmodule

// File: rtl/spi_mm_node.sv
`timescale 1ns/1ps
module spi_mm_node
  import spi_mm_pkg::*;
#(
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned BO_W    = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sw_sel_en_i,
  input  logic               sw_sel_val_i,
  input  logic               sel_out_en_i,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  input  logic [DIV_W-1:0]   clk_div_i,
  input  logic [BO_W-1:0]    backoff_i,
  input  logic               fault_clr_i,
  input  logic [FRAME_W-1:0] slv_tx_data_i,
  output logic               master_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               fault_o,
  output logic [FRAME_W-1:0] slv_rx_data_o,
  output logic               slv_rx_valid_o,
  output logic               sck_o,
  output logic               sck_oe_o,
  output logic               mosi_o,
  output logic               mosi_oe_o,
  input  logic               miso_i,
  input  logic               sck_i,
  input  logic               mosi_i,
  output logic               miso_o,
  output logic               miso_oe_o,
  input  logic               nss_i,
  output logic               nss_o,
  output logic               nss_oe_o,
  output logic               peer_sel_o
);
  node_st_e st_q, st_d;

  logic nss_s, sck_s, mosi_s;
  logic sel_n, in_mode, is_master, slv_sel, fault_evt, start_ok;
  logic eng_load, bo_load, bo_zero, eng_fin, eng_sck, eng_mosi;
  logic [FRAME_W-1:0] eng_rx, tx_hold_q, eng_data, rx_q;
  logic [DIV_W-1:0]   half_m1;
  logic fault_q, done_q;

  spi_mm_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({nss_i, sck_i, mosi_i}),
    .q_o   ({nss_s, sck_s, mosi_s})
  );

  assign sel_n     = sw_sel_en_i ? sw_sel_val_i : nss_s;
  assign in_mode   = sw_sel_en_i | ~sel_out_en_i;
  assign is_master = (st_q == ST_XFER);
  assign slv_sel   = ~is_master & ~sel_n;
  assign fault_evt = is_master & in_mode & ~sel_n;
  assign start_ok  = start_i & (st_q == ST_IDLE) & ~slv_sel;
  assign half_m1   = (clk_div_i < DIV_W'(2)) ? '0 : (clk_div_i >> 1) - DIV_W'(1);

  always_comb begin
    st_d     = st_q;
    eng_load = 1'b0;
    bo_load  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_ok) begin
        st_d     = ST_XFER;
        eng_load = 1'b1;
      end
      ST_XFER: begin
        if (fault_evt) begin
          st_d    = ST_BACKOFF;
          bo_load = 1'b1;
        end else if (eng_fin) begin
          st_d = ST_IDLE;
        end
      end
      ST_BACKOFF: begin
        if (slv_sel) begin
          st_d = ST_IDLE;
        end else if (bo_zero) begin
          st_d     = ST_XFER;
          eng_load = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      tx_hold_q <= '0;
      rx_q      <= '0;
      fault_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= is_master & eng_fin & ~fault_evt;
      if (start_ok) tx_hold_q <= tx_data_i;
      if (is_master & eng_fin & ~fault_evt) rx_q <= eng_rx;
      if (fault_evt)        fault_q <= 1'b1;
      else if (fault_clr_i) fault_q <= 1'b0;
    end
  end

  assign eng_data = (st_q == ST_IDLE) ? tx_data_i : tx_hold_q;

  spi_mm_master_shift #(.FRAME_W(FRAME_W), .DIV_W(DIV_W)) u_mst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (eng_load),
    .run_i    (is_master),
    .half_m1_i(half_m1),
    .data_i   (eng_data),
    .miso_i   (miso_i),
    .sck_o    (eng_sck),
    .mosi_o   (eng_mosi),
    .fin_o    (eng_fin),
    .rx_o     (eng_rx)
  );

  spi_mm_slave_shift #(.FRAME_W(FRAME_W)) u_slv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (slv_sel),
    .sck_s_i   (sck_s),
    .mosi_s_i  (mosi_s),
    .tx_data_i (slv_tx_data_i),
    .miso_o    (miso_o),
    .rx_data_o (slv_rx_data_o),
    .rx_valid_o(slv_rx_valid_o)
  );

  spi_mm_backoff #(.BO_W(BO_W)) u_bo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(bo_load),
    .run_i (st_q == ST_BACKOFF),
    .val_i (backoff_i),
    .zero_o(bo_zero)
  );

  assign master_o   = is_master;
  assign done_o     = done_q;
  assign rx_data_o  = rx_q;
  assign fault_o    = fault_q;
  assign sck_o      = eng_sck & is_master;
  assign sck_oe_o   = is_master;
  assign mosi_o     = eng_mosi;
  assign mosi_oe_o  = is_master;
  assign miso_oe_o  = slv_sel;
  assign nss_o      = ~is_master;
  assign nss_oe_o   = is_master & ~in_mode;
  assign peer_sel_o = ~is_master;

  p_fault_drops_master_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_evt |=> !master_o && peer_sel_o && !sck_oe_o);

  p_fault_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !fault_clr_i) |=> fault_o);

  p_done_after_master_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(st_q) == ST_XFER) && peer_sel_o);

  p_miso_oe_slave_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_oe_o |-> !master_o);

  p_no_start_sel_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && slv_sel) |=> !master_o);
endmodule

// File: tb/spi_mm_node_tb.sv
`timescale 1ns/1ps
module spi_mm_node_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic sw_sel_en = 0, sw_sel_val = 1, sel_out_en = 0, start = 0, fault_clr = 0;
  logic [7:0] tx_data = 0, slv_tx = 0;
  logic [7:0] clk_div = 8'd4;
  logic [15:0] backoff = 16'd20;
  logic sck_in = 0, mosi_in = 0, nss_in = 1, inv = 0;
  logic master, done, fault, slv_valid, sck, sck_oe, mosi, mosi_oe, miso_out, miso_oe, nss_out, nss_oe, peer_sel;
  logic [7:0] rx_data, slv_rx;
  logic miso_in;

  assign miso_in = mosi ^ inv;

  spi_mm_node u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sw_sel_en_i(sw_sel_en), .sw_sel_val_i(sw_sel_val),
    .sel_out_en_i(sel_out_en), .start_i(start), .tx_data_i(tx_data), .clk_div_i(clk_div),
    .backoff_i(backoff), .fault_clr_i(fault_clr), .slv_tx_data_i(slv_tx),
    .master_o(master), .done_o(done), .rx_data_o(rx_data), .fault_o(fault),
    .slv_rx_data_o(slv_rx), .slv_rx_valid_o(slv_valid), .sck_o(sck), .sck_oe_o(sck_oe),
    .mosi_o(mosi), .mosi_oe_o(mosi_oe), .miso_i(miso_in), .sck_i(sck_in), .mosi_i(mosi_in),
    .miso_o(miso_out), .miso_oe_o(miso_oe), .nss_i(nss_in), .nss_o(nss_out),
    .nss_oe_o(nss_oe), .peer_sel_o(peer_sel)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  typedef struct packed { logic [7:0] tx; logic [7:0] div; logic inv; } vec_t;
  localparam vec_t VEC [5] = '{
    '{tx: 8'hA5, div: 8'd2, inv: 1'b0},
    '{tx: 8'h3C, div: 8'd4, inv: 1'b1},
    '{tx: 8'h00, div: 8'd6, inv: 1'b0},
    '{tx: 8'hFF, div: 8'd2, inv: 1'b1},
    '{tx: 8'h81, div: 8'd8, inv: 1'b0}
  };

  task automatic pulse_start(input logic [7:0] b);
    @(negedge clk); tx_data = b; start = 1;
    @(negedge clk); start = 0;
  endtask

  // runs from the first negedge of the session until master drops
  task automatic wait_end(output int hi, output logic [7:0] cap, output int dn, output int psel_low);
    logic prev = 0;
    hi = 0; cap = 0; dn = 0; psel_low = 0;
    for (int i = 0; i < 4000; i++) begin
      if (master) begin
        hi++;
        if (!peer_sel) psel_low++;
        if (sck && !prev) cap = {cap[6:0], mosi};
        prev = sck;
      end else if (hi > 0) begin
        break;
      end
      @(negedge clk);
    end
    if (done) dn++;
    @(negedge clk);
    if (done) dn++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hi, dn, pl, gap;
    logic [7:0] cap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!master && !sck_oe && !mosi_oe && !nss_oe && peer_sel && !fault && !done, "R1",
        {master, sck_oe, mosi_oe, nss_oe, peer_sel, fault}, 6'b000010);

    // table-driven master frames
    foreach (VEC[k]) begin
      clk_div = VEC[k].div; inv = VEC[k].inv;
      pulse_start(VEC[k].tx);
      wait_end(hi, cap, dn, pl);
      chk(hi == 8 * int'(VEC[k].div), "R2 frame length", hi, 8 * int'(VEC[k].div));
      chk(pl == hi, "R2 peer select low", pl, hi);
      chk(cap == VEC[k].tx, "R3 mosi msb first", cap, VEC[k].tx);
      chk(rx_data == (VEC[k].tx ^ {8{VEC[k].inv}}), "R3 rx byte", rx_data, VEC[k].tx ^ {8{VEC[k].inv}});
      chk(dn == 1, "R4 done pulse", dn, 1);
      chk(peer_sel && !sck_oe && !mosi_oe, "R1 idle after frame", {peer_sel, sck_oe, mosi_oe}, 3'b100);
    end
    inv = 0; clk_div = 8'd4;

    // R13 / R5 slave select latency and slave frame
    slv_tx = 8'hC6;
    @(negedge clk); nss_in = 0;
    @(negedge clk);
    chk(!miso_oe, "R13 one flop not enough", miso_oe, 0);
    @(negedge clk);
    chk(miso_oe, "R13 two flops", miso_oe, 1);
    for (int b = 7; b >= 0; b--) begin
      mosi_in = (8'h5B >> b) & 1;
      repeat (4) @(negedge clk);
      chk(miso_out == slv_tx[b], "R5 miso bit", miso_out, slv_tx[b]);
      sck_in = 1;
      for (int w = 0; w < 4; w++) begin
        @(negedge clk);
        if (b == 0 && slv_valid) chk(slv_rx == 8'h5B, "R5 slave rx", slv_rx, 8'h5B);
      end
      sck_in = 0;
      repeat (4) @(negedge clk);
    end
    chk(slv_rx == 8'h5B, "R5 slave rx held", slv_rx, 8'h5B);

    // R12 start ignored while selected
    pulse_start(8'h77);
    gap = 0;
    repeat (40) begin @(negedge clk); if (master) gap++; end
    chk(gap == 0, "R12 start ignored", gap, 0);
    nss_in = 1;
    repeat (4) @(negedge clk);

    // R6 software select: nss_i ignored
    sw_sel_en = 1; sw_sel_val = 1; nss_in = 0;
    repeat (4) @(negedge clk);
    chk(!miso_oe, "R6 nss ignored", miso_oe, 0);
    pulse_start(8'h96);
    wait_end(hi, cap, dn, pl);
    chk(!fault && rx_data == 8'h96, "R6 no fault in sw mode", {fault, rx_data}, 9'h096);
    sw_sel_val = 0;
    @(negedge clk);
    chk(miso_oe, "R6 sw select", miso_oe, 1);
    sw_sel_val = 1;
    @(negedge clk);

    // R7 / R11 software fault with cancelled retry
    pulse_start(8'h42);
    repeat (5) @(negedge clk);
    sw_sel_val = 0;
    @(negedge clk);
    chk(!master && peer_sel && !sck_oe && !mosi_oe, "R7 released", {master, peer_sel, sck_oe, mosi_oe}, 4'b0100);
    chk(fault, "R9 fault set", fault, 1);
    gap = 0;
    repeat (60) begin @(negedge clk); if (master) gap++; end
    chk(gap == 0, "R11 retry cancelled", gap, 0);
    chk(miso_oe, "R11 slave selected", miso_oe, 1);
    sw_sel_val = 1; sw_sel_en = 0; nss_in = 1;
    repeat (4) @(negedge clk);
    chk(fault, "R9 sticky", fault, 1);
    fault_clr = 1;
    @(negedge clk); fault_clr = 0;
    chk(!fault, "R9 cleared", fault, 0);

    // R10 hardware input mode glitch, retry after backoff
    backoff = 16'd20;
    pulse_start(8'hE3);
    repeat (6) @(negedge clk);
    nss_in = 0;
    @(negedge clk); nss_in = 1;
    for (int i = 0; i < 10; i++) begin
      if (!master) break;
      @(negedge clk);
    end
    chk(!master && fault && peer_sel, "R7 hw fault", {master, fault, peer_sel}, 3'b011);
    gap = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (master) break;
      gap++;
    end
    chk(gap == 21, "R10 backoff length", gap, 21);
    tx_data = 8'h00;
    wait_end(hi, cap, dn, pl);
    chk(rx_data == 8'hE3 && cap == 8'hE3, "R10 retried byte", rx_data, 8'hE3);
    chk(dn == 1, "R4 done after retry", dn, 1);
    fault_clr = 1;
    @(negedge clk); fault_clr = 0;

    // R8 output mode: nss driven, glitch ignored
    sel_out_en = 1;
    pulse_start(8'h5A);
    repeat (3) @(negedge clk);
    chk(nss_oe && !nss_out, "R8 nss driven", {nss_oe, nss_out}, 2'b10);
    nss_in = 0;
    @(negedge clk); nss_in = 1;
    wait_end(hi, cap, dn, pl);
    chk(!fault && rx_data == 8'h5A && dn == 1, "R8 no fault", {fault, rx_data}, 9'h05A);
    chk(!nss_oe, "R8 nss released", nss_oe, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule